// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers five reset requests and turns them into one system reset with a controlled release. The requests are an active-low external pin, a watchdog overflow, a main-oscillator stop flag, a power-on-clear comparator and a low-voltage comparator. The analog comparators, the oscillators, the watchdog and the clock monitor sit outside the block and reach it only as digital levels. The block runs from the internal ring-oscillator clock.

The watchdog and oscillator-stop requests are events. Each one holds reset for a programmable number of cycles and then lets go without outside help. A low-voltage request holds reset for as long as its comparator reports a low supply. The power-on-clear comparator is the block's own asynchronous reset. The external pin counts only once it has stayed low for a minimum number of clock cycles.

Each release is followed by a fixed stabilisation window of 17 ring-oscillator cycles. The CPU clock stays off during this window, and the ports stay in their safe state. A cause register shows which sources have fired, and software can clear its bits one at a time. The block also exports a fixed vector address of zero.

Top module: `rst_seq_top`

## Requirements
- R1: While `poc_low` is 1, the block sits in IN_RESET with `sys_rst_n`=0 and `cpu_clk_en`=0. The assertion takes effect at once, without waiting for a clock edge.
- R2: If `ext_rst_n` stays low for at least `EXT_MIN_CYC` consecutive clock cycles, a reset follows. A shorter low pulse changes neither the sequence state nor the cause register.
- R3: A rising level on `wdt_ovf` or `osc_stop` holds IN_RESET for at least `PULSE_CYC` cycles. The block then leaves reset with no further input.
- R4: IN_RESET lasts at least as many cycles as `lvd_low` is held at 1.
- R5: Leaving IN_RESET, the block spends exactly `STAB_CYC` (17) cycles in STABILISING with `cpu_clk_en`=0 before it enters RUNNING.
- R6: A new request during STABILISING sends the block back to IN_RESET. After that request releases, a full `STAB_CYC` count runs from zero.
- R7: `port_hiz` and `pin_drv_low` are 1 in every state except RUNNING. `cpu_clk_en` is 1 only in RUNNING. `sys_rst_n` is 0 only in IN_RESET.
- R8: The `rst_cause` bits are: bit0 external, bit1 watchdog, bit2 oscillator stop, bit3 power-on-clear, bit4 low voltage. A source sets its own bit, and the bit stays set through later resets that are not power-on-clear resets.
- R9: A power-on-clear reset sets `rst_cause` to 5'b01000.
- R10: A one-cycle `clr_stb` clears exactly the `rst_cause` bits that are 1 in `clr_mask`.
- R11: `seq_state` reads 0 in IN_RESET, 1 in STABILISING and 2 in RUNNING. `vec_addr` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ro | input | 1 | Ring-oscillator clock |
| poc_low | input | 1 | Power-on-clear comparator, 1 = supply below level (asynchronous reset) |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow |
| osc_stop | input | 1 | Main-oscillator stop flag from the clock monitor |
| lvd_low | input | 1 | Low-voltage comparator, 1 = supply below level |
| clr_stb | input | 1 | Cause-register clear strobe |
| clr_mask | input | 5 | Cause bits to clear when `clr_stb` is 1 |
| sys_rst_n | output | 1 | System reset, active low |
| cpu_clk_en | output | 1 | CPU clock enable |
| port_hiz | output | 1 | Puts the general ports in high impedance |
| pin_drv_low | output | 1 | Drives the designated pin low |
| rst_cause | output | 5 | Sticky reset-cause bits |
| seq_state | output | 2 | Sequence state |
| vec_addr | output | 16 | Reset vector address, fixed at 0 |

## Verification
A table drives each source in turn. The table includes an external low pulse one cycle shorter than the filter minimum and one exactly at the minimum, which separates a rejected pulse from an accepted one at the exact boundary. Single-cycle and multi-cycle event pulses show that the event sources release by themselves. A long low-voltage level shows that the reset lasts as long as the level. Directed tests inject a request in the middle of the stabilisation window to check the restart, set cause bits in sequence and clear them partially to check stickiness and clearing, and raise power-on-clear between clock edges to check the immediate assertion and the cause wipe.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IN_RESET    = 2'd0,
    SEQ_STABILISING = 2'd1,
    SEQ_RUNNING     = 2'd2
  } seq_state_e;

  localparam int SRC_EXT = 0;
  localparam int SRC_WDT = 1;
  localparam int SRC_OSC = 2;
  localparam int SRC_POC = 3;
  localparam int SRC_LVD = 4;
  localparam int NUM_SRC = 5;

  // True when a counter sits on the final cycle of a window of lim cycles.
  function automatic logic last_count(input int unsigned cnt, input int unsigned lim);
    return cnt == lim - 1;
  endfunction

  // Cause update: write-one-to-clear first, then new events set bits (set wins).
  function automatic logic [NUM_SRC-1:0] cause_next(input logic [NUM_SRC-1:0] cur,
                                                     input logic [NUM_SRC-1:0] set,
                                                     input logic               clr_en,
                                                     input logic [NUM_SRC-1:0] clr_msk);
    logic [NUM_SRC-1:0] kill;
    kill = clr_en ? clr_msk : '0;
    return (cur & ~kill) | set;
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         arst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      meta   <= '0;
      d_sync <= '0;
    end else begin
      meta   <= d_async;
      d_sync <= meta;
    end
  end
endmodule

// File: rtl/ext_filter.sv
module ext_filter #(
  parameter int MIN_CYC = 8
) (
  input  logic clk,
  input  logic arst,
  input  logic low_s,
  output logic req
);
  localparam int CW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] run_cnt;
  logic          at_min;

  assign at_min = rst_seq_pkg::last_count(32'(run_cnt), MIN_CYC);
  assign req    = low_s && at_min;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)         run_cnt <= '0;
    else if (!low_s)  run_cnt <= '0;
    else if (!at_min) run_cnt <= run_cnt + 1'b1;
  end
endmodule

// File: rtl/pulse_hold.sv
module pulse_hold #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic arst,
  input  logic flag_s,
  output logic start,
  output logic hold
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic          flag_q;
  logic [CW-1:0] left;

  assign start = flag_s && !flag_q;
  assign hold  = (left != '0);

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      flag_q <= 1'b0;
      left   <= '0;
    end else begin
      flag_q <= flag_s;
      if (start)     left <= CW'(HOLD_CYC);
      else if (hold) left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/rst_fsm.sv
module rst_fsm
  import rst_seq_pkg::*;
#(
  parameter int STAB_CYC = 17
) (
  input  logic       clk,
  input  logic       arst,
  input  logic       req,
  output seq_state_e state
);
  localparam int SW = $clog2(STAB_CYC + 1);

  logic [SW-1:0] stab_cnt;
  logic          stab_end;

  assign stab_end = last_count(32'(stab_cnt), STAB_CYC);

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      state    <= SEQ_IN_RESET;
      stab_cnt <= '0;
    end else begin
      unique case (state)
        SEQ_IN_RESET: begin
          stab_cnt <= '0;
          if (!req) state <= SEQ_STABILISING;
        end
        SEQ_STABILISING: begin
          if (req) begin
            state    <= SEQ_IN_RESET;
            stab_cnt <= '0;
          end else if (stab_end) begin
            state    <= SEQ_RUNNING;
          end else begin
            stab_cnt <= stab_cnt + 1'b1;
          end
        end
        SEQ_RUNNING: if (req) state <= SEQ_IN_RESET;
        default: state <= SEQ_IN_RESET;
      endcase
    end
  end
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int EXT_MIN_CYC = 8,
  parameter int PULSE_CYC   = 4,
  parameter int STAB_CYC    = 17,
  parameter int VEC_AW      = 16
) (
  input  logic               clk_ro,
  input  logic               poc_low,
  input  logic               ext_rst_n,
  input  logic               wdt_ovf,
  input  logic               osc_stop,
  input  logic               lvd_low,
  input  logic               clr_stb,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic               sys_rst_n,
  output logic               cpu_clk_en,
  output logic               port_hiz,
  output logic               pin_drv_low,
  output logic [NUM_SRC-1:0] rst_cause,
  output logic [1:0]         seq_state,
  output logic [VEC_AW-1:0]  vec_addr
);
  localparam int NUM_PULSE = 2;

  // Synchronised view: {lvd, osc, wdt, ext_low}
  logic [3:0] raw_in, syn_in;
  assign raw_in = {lvd_low, osc_stop, wdt_ovf, ~ext_rst_n};

  rst_sync #(.W(4)) i_sync (
    .clk(clk_ro), .arst(poc_low), .d_async(raw_in), .d_sync(syn_in)
  );

  logic ext_req;
  ext_filter #(.MIN_CYC(EXT_MIN_CYC)) i_ext (
    .clk(clk_ro), .arst(poc_low), .low_s(syn_in[0]), .req(ext_req)
  );

  logic [NUM_PULSE-1:0] pulse_flag, pulse_start_v, pulse_hold_v;
  assign pulse_flag = syn_in[2:1];

  for (genvar g = 0; g < NUM_PULSE; g++) begin : g_pulse
    pulse_hold #(.HOLD_CYC(PULSE_CYC)) i_hold (
      .clk(clk_ro), .arst(poc_low), .flag_s(pulse_flag[g]),
      .start(pulse_start_v[g]), .hold(pulse_hold_v[g])
    );
  end

  logic pulse_start, lvd_req, any_req;
  assign pulse_start = |pulse_start_v;
  assign lvd_req     = syn_in[3];
  assign any_req     = ext_req | pulse_start | (|pulse_hold_v) | lvd_req;

  seq_state_e state;
  rst_fsm #(.STAB_CYC(STAB_CYC)) i_fsm (
    .clk(clk_ro), .arst(poc_low), .req(any_req), .state(state)
  );

  logic [NUM_SRC-1:0] cause_set;
  always_comb begin
    cause_set          = '0;
    cause_set[SRC_EXT] = ext_req;
    cause_set[SRC_WDT] = pulse_start_v[0];
    cause_set[SRC_OSC] = pulse_start_v[1];
    cause_set[SRC_LVD] = lvd_req;
  end

  always_ff @(posedge clk_ro or posedge poc_low) begin
    if (poc_low) rst_cause <= NUM_SRC'(1) << SRC_POC;
    else         rst_cause <= cause_next(rst_cause, cause_set, clr_stb, clr_mask);
  end

  assign seq_state   = state;
  assign sys_rst_n   = (state != SEQ_IN_RESET);
  assign cpu_clk_en  = (state == SEQ_RUNNING);
  assign port_hiz    = (state != SEQ_RUNNING);
  assign pin_drv_low = (state != SEQ_RUNNING);
  assign vec_addr    = '0;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk
  import rst_seq_pkg::*;
#(
  parameter int STAB_CYC = 17
) (
  input logic               clk,
  input logic               poc_low,
  input logic [1:0]         seq_state,
  input logic               cpu_clk_en,
  input logic               port_hiz,
  input logic               sys_rst_n,
  input logic               lvd_req,
  input logic               pulse_start,
  input logic               clr_stb,
  input logic [NUM_SRC-1:0] rst_cause
);
  int unsigned stab_seen;

  always_ff @(posedge clk or posedge poc_low) begin
    if (poc_low)                         stab_seen <= 0;
    else if (seq_state == SEQ_STABILISING) stab_seen <= stab_seen + 1;
    else                                 stab_seen <= 0;
  end

  AST_STAB_BOUND: assert property (@(posedge clk) disable iff (poc_low)
    (seq_state == SEQ_STABILISING) |-> (stab_seen < STAB_CYC)); // R5

  AST_RUN_AFTER_FULL_STAB: assert property (@(posedge clk) disable iff (poc_low)
    (seq_state == SEQ_RUNNING && $past(seq_state) != SEQ_RUNNING)
      |-> ($past(seq_state) == SEQ_STABILISING && $past(stab_seen) == STAB_CYC - 1)); // R6

  AST_LVD_HOLDS: assert property (@(posedge clk) disable iff (poc_low)
    lvd_req |=> (seq_state == SEQ_IN_RESET)); // R4

  AST_PULSE_RESETS: assert property (@(posedge clk) disable iff (poc_low)
    pulse_start |=> (seq_state == SEQ_IN_RESET)); // R3

  AST_CLK_SAFE: assert property (@(posedge clk) disable iff (poc_low)
    cpu_clk_en |-> (!port_hiz && sys_rst_n)); // R7

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (poc_low)
    !clr_stb |=> (($past(rst_cause) & ~rst_cause) == '0)); // R8
endmodule

bind rst_seq_top rst_seq_chk #(.STAB_CYC(STAB_CYC)) i_chk (
  .clk(clk_ro), .poc_low(poc_low), .seq_state(seq_state),
  .cpu_clk_en(cpu_clk_en), .port_hiz(port_hiz), .sys_rst_n(sys_rst_n),
  .lvd_req(lvd_req), .pulse_start(pulse_start), .clr_stb(clr_stb),
  .rst_cause(rst_cause)
);

// File: tb/test_rst_seq_top.sv
module test_rst_seq_top;
  localparam int EXT_MIN = 8;
  localparam int PULSE   = 4;
  localparam int STAB    = 17;
  localparam int NCASE   = 7;
  // {src[3:0], len[7:0], accepted[3:0]}; src 0 ext, 1 wdt, 2 osc, 4 lvd
  localparam logic [15:0] CASES [NCASE] = '{
    16'h0070, 16'h0081, 16'h0141, 16'h1011, 16'h2031, 16'h41E1, 16'h1021
  };

  logic clk = 0;
  logic poc_low = 1, ext_rst_n = 1, wdt_ovf = 0, osc_stop = 0, lvd_low = 0;
  logic clr_stb = 0;
  logic [4:0] clr_mask = '0;
  logic sys_rst_n, cpu_clk_en, port_hiz, pin_drv_low;
  logic [4:0] rst_cause;
  logic [1:0] seq_state;
  logic [15:0] vec_addr;

  int errors = 0, checks = 0, cycles = 0, mon_err = 0;
  int rst_run = 0, rst_len = 0, stab_run = 0, stab_len = 0;
  bit saw_reset = 0, interrupted = 0;
  logic [1:0] prev_state = 2'd0;

  always #10 clk = ~clk;

  rst_seq_top #(.EXT_MIN_CYC(EXT_MIN), .PULSE_CYC(PULSE), .STAB_CYC(STAB), .VEC_AW(16))
  i_rst_seq_top (
    .clk_ro(clk), .poc_low(poc_low), .ext_rst_n(ext_rst_n), .wdt_ovf(wdt_ovf),
    .osc_stop(osc_stop), .lvd_low(lvd_low), .clr_stb(clr_stb), .clr_mask(clr_mask),
    .sys_rst_n(sys_rst_n), .cpu_clk_en(cpu_clk_en), .port_hiz(port_hiz),
    .pin_drv_low(pin_drv_low), .rst_cause(rst_cause), .seq_state(seq_state),
    .vec_addr(vec_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: run lengths per state and output coherence (R7, R11)
  always @(negedge clk) begin
    cycles++;
    if (seq_state == 2'd0) begin rst_run++; saw_reset = 1; end
    else if (prev_state == 2'd0) begin rst_len = rst_run; rst_run = 0; end
    if (seq_state == 2'd1) stab_run++;
    else if (prev_state == 2'd1) begin
      if (seq_state == 2'd0) interrupted = 1; else stab_len = stab_run;
      stab_run = 0;
    end
    prev_state = seq_state;
    if (port_hiz !== (seq_state != 2'd2) || pin_drv_low !== (seq_state != 2'd2) ||
        cpu_clk_en !== (seq_state == 2'd2) || sys_rst_n !== (seq_state != 2'd0) ||
        vec_addr !== 16'h0 || seq_state === 2'd3)
      mon_err++;
  end

  task automatic wait_run();
    for (int n = 0; n < 1000 && seq_state != 2'd2; n++) @(negedge clk);
  endtask

  task automatic drive_src(input int src, input logic v);
    case (src)
      0: ext_rst_n = !v;
      1: wdt_ovf   = v;
      2: osc_stop  = v;
      default: lvd_low = v;
    endcase
  endtask

  task automatic clear(input logic [4:0] m);
    @(negedge clk); clr_stb = 1; clr_mask = m;
    @(negedge clk); clr_stb = 0; clr_mask = '0;
    @(negedge clk);
  endtask

  task automatic pulse(input int src, input int len);
    @(negedge clk); saw_reset = 0; drive_src(src, 1);
    repeat (len) @(negedge clk);
    drive_src(src, 0);
    repeat (8) @(negedge clk);
    wait_run();
    repeat (3) @(negedge clk);
  endtask

  function automatic string tag(input int src);
    case (src)
      0: return "R2";
      1, 2: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    #100000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 / R9 / R11: reset state while power-on-clear is active
    repeat (3) @(negedge clk);
    check("R1 state", seq_state, 0);
    check("R1 sys_rst_n", sys_rst_n, 0);
    check("R1 cpu_clk_en", cpu_clk_en, 0);
    check("R7 port_hiz", port_hiz, 1);
    check("R9 cause", rst_cause, 5'b01000);
    check("R11 vec_addr", vec_addr, 0);
    poc_low = 0;
    wait_run();
    repeat (2) @(negedge clk);
    check("R5 stab length", stab_len, STAB);
    check("R9 cause after release", rst_cause, 5'b01000);
    clear(5'b01000);
    check("R10 clear poc bit", rst_cause, 0);

    // Vector table
    for (int i = 0; i < NCASE; i++) begin
      int src = int'(CASES[i][15:12]);
      int len = int'(CASES[i][11:4]);
      bit acc = CASES[i][0];
      stab_len = 0;
      pulse(src, len);
      check($sformatf("%s accept case %0d", tag(src), i), saw_reset, acc);
      check($sformatf("R8 cause case %0d", i), rst_cause, acc ? (5'b1 << src) : 5'b0);
      if (acc) begin
        check($sformatf("R5 stab case %0d", i), stab_len, STAB);
        if (src == 4) check("R4 held", rst_len >= len, 1);
        else if (src != 0) check("R3 min hold", rst_len >= PULSE, 1);
      end
      clear(5'b11111);
    end

    // R8 sticky across pulse resets, R10 partial clear
    pulse(1, 1);
    pulse(2, 2);
    check("R8 sticky", rst_cause, 5'b00110);
    clear(5'b00010);
    check("R10 partial clear", rst_cause, 5'b00100);

    // R6 restart of the stabilisation count
    interrupted = 0; stab_len = 0;
    @(negedge clk); wdt_ovf = 1; @(negedge clk); wdt_ovf = 0;
    for (int n = 0; n < 200 && seq_state != 2'd1; n++) @(negedge clk);
    repeat (5) @(negedge clk);
    osc_stop = 1; @(negedge clk); osc_stop = 0;
    repeat (8) @(negedge clk);
    wait_run();
    repeat (2) @(negedge clk);
    check("R6 interrupted", interrupted, 1);
    check("R6 full recount", stab_len, STAB);

    // R1 / R9: asynchronous power-on-clear mid-run
    lvd_low = 1; repeat (6) @(negedge clk); lvd_low = 0;
    wait_run();
    #3 poc_low = 1;
    #1;
    check("R1 async sys_rst_n", sys_rst_n, 0);
    check("R9 cause wipe", rst_cause, 5'b01000);
    @(negedge clk); poc_low = 0;
    wait_run();
    repeat (2) @(negedge clk);
    check("R7 R11 monitor", mon_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule